// File: doc/BRIEF.md
# Ones-Complement Rotating Checksum Engine

This engine walks a block of 16-bit words held in memory and folds them into a single checksum. Each word is added to a running sum. Any carry out of the top bit is added back in at the bottom, and the sum is then rotated left by one bit. When the block is finished, an all-ones result (the ones-complement negative zero) is reported as zero.

A caller pulses `start` with a start address, a word count and an initial sum, which is zero for a fresh computation. The engine fetches words through a request port with valid/ready back-pressure. It pulses `done` when it has the final value.

The engine can be interrupted. While `irq_mask` is low, a pending `irq_req` seen before a word is added stops the engine, and `interrupted` pulses instead of `done`. The outputs then hold the partial sum, the address of the first word not yet added and the number of words left. Restarting with those three values gives the same final checksum as an uninterrupted run.

Memory port rules:
- The engine holds `mem_req_valid` high with a steady `mem_addr` until `mem_req_ready` is seen high at a clock edge.
- The memory places the word on `mem_rdata` in the cycle after that edge.
- Holding `mem_req_ready` low simply stretches the run.

Top module: `cks_engine`

## Requirements
- R1: Adding a word whose sum with the running value carries out of bit 15 adds 1 back into the low end (end-around carry). For example, 16'h8000 + 16'h8000 folds to 16'h0001.
- R2: After each word's add and carry fold, the 16-bit sum is rotated left by one bit, with bit 15 moving to bit 0. With initial sum 0, the single word 16'h8001 gives 16'h0003.
- R3: When the count runs out, a final value of 16'hFFFF is reported as 16'h0000. All other values are reported unchanged, and `done` never shows 16'hFFFF.
- R4: The run starts from the supplied initial sum. The address rises by one and the remaining count falls by one for each word added. The final checksum equals that of a software model of the same block.
- R5: The interrupt request is sampled once per word, in the cycle the fetched word arrives. If it is pending and unmasked, the engine stops without adding that word and pulses `interrupted`. The sum, count and address outputs then hold the partial state: `next_addr` is the start address plus the number of words added.
- R6: Starting again with the held sum, address and count finishes with the same checksum as an uninterrupted run.
- R7: While `irq_mask` is high, pending requests are ignored and the run completes with `done`.
- R8: A start with count 0 issues no memory request. It pulses `done` one clock edge after start is sampled, returning the initial sum with the R3 rule applied.
- R9: A request stays valid with a stable address until accepted. With `mem_req_ready` always high, `done` appears 2N+1 edges after start is sampled for N words, which is 2 cycles per word and well under 9.
- R10: `done` and `interrupted` are one-cycle pulses and never high together. A start while busy is ignored. The result outputs stay unchanged after `done` until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled only while idle |
| start_addr | input | ADDR_W | Address of the first word |
| start_count | input | CNT_W | Number of words to fold |
| start_sum | input | DATA_W | Initial running sum |
| irq_req | input | 1 | Pending interrupt request |
| irq_mask | input | 1 | High disables the interrupt check |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | DATA_W | Read data, valid the cycle after acceptance |
| busy | output | 1 | Engine is running |
| done | output | 1 | Completion pulse |
| interrupted | output | 1 | Early-stop pulse |
| sum_out | output | DATA_W | Running, partial or final sum |
| next_addr | output | ADDR_W | Address of the next word to add |
| remain_count | output | CNT_W | Words still to add |

## Verification
The bench builds the engine with its default widths: 16-bit data, address and count. At these widths the end-around carry, the 16'hFFFF negative-zero rewrite and a one-bit rotate all appear in short hand-worked blocks, and a 64-word model memory is enough to cover them. Every vector runs both with a port that is always ready and with a port that accepts only one cycle in three, so back-pressure is exercised.

// File: rtl/cks_pkg.sv
package cks_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACC  = 2'd2
  } cks_state_e;
endpackage

// File: rtl/cks_sum_unit.sv
module cks_sum_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] sum_in,
  input  logic [W-1:0] word_in,
  input  logic [W-1:0] fix_in,
  output logic [W-1:0] step_out,
  output logic [W-1:0] fixed_out
);
  logic [W:0]   wide;
  logic [W-1:0] folded;

  always_comb begin
    wide   = {1'b0, sum_in} + {1'b0, word_in};
    folded = wide[W-1:0] + {{(W-1){1'b0}}, wide[W]};
  end

  generate
    if (W > 1) begin : g_rot
      assign step_out = {folded[W-2:0], folded[W-1]};
    end else begin : g_norot
      assign step_out = folded;
    end
  endgenerate

  assign fixed_out = (&fix_in) ? '0 : fix_in;
endmodule

// File: rtl/cks_ctrl.sv
module cks_ctrl
  import cks_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic count_is_zero,
  input  logic count_is_last,
  input  logic irq_req,
  input  logic irq_mask,
  input  logic mem_req_ready,
  output logic mem_req_valid,
  output logic busy,
  output logic do_load,
  output logic do_step,
  output logic do_done,
  output logic do_intr
);
  cks_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    do_load = 1'b0;
    do_step = 1'b0;
    do_done = 1'b0;
    do_intr = 1'b0;
    mem_req_valid = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        do_load = 1'b1;
        if (count_is_zero) do_done = 1'b1;
        else state_d = ST_REQ;
      end
      ST_REQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = ST_ACC;
      end
      ST_ACC: begin
        if (irq_req && !irq_mask) begin
          do_intr = 1'b1;
          state_d = ST_IDLE;
        end else begin
          do_step = 1'b1;
          if (count_is_last) begin
            do_done = 1'b1;
            state_d = ST_IDLE;
          end else state_d = ST_REQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q != ST_IDLE);

  assert_masked_runs_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACC && irq_mask && irq_req) |-> (do_step && !do_intr));
  assert_req_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid);
endmodule

// File: rtl/cks_engine.sv
module cks_engine #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_count,
  input  logic [DATA_W-1:0] start_sum,
  input  logic              irq_req,
  input  logic              irq_mask,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              interrupted,
  output logic [DATA_W-1:0] sum_out,
  output logic [ADDR_W-1:0] next_addr,
  output logic [CNT_W-1:0]  remain_count
);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [DATA_W-1:0] sum_q, step_sum, fix_src, fixed_sum;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q, intr_q;
  logic              do_load, do_step, do_done, do_intr;

  cks_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .count_is_zero (start_count == '0),
    .count_is_last (cnt_q == CNT_ONE),
    .irq_req       (irq_req),
    .irq_mask      (irq_mask),
    .mem_req_ready (mem_req_ready),
    .mem_req_valid (mem_req_valid),
    .busy          (busy),
    .do_load       (do_load),
    .do_step       (do_step),
    .do_done       (do_done),
    .do_intr       (do_intr)
  );

  assign fix_src = do_load ? start_sum : step_sum;

  cks_sum_unit #(.W(DATA_W)) u_sum (
    .sum_in    (sum_q),
    .word_in   (mem_rdata),
    .fix_in    (fix_src),
    .step_out  (step_sum),
    .fixed_out (fixed_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      done_q <= do_done;
      intr_q <= do_intr;
      if (do_load) begin
        addr_q <= start_addr;
        cnt_q  <= start_count;
        sum_q  <= do_done ? fixed_sum : start_sum;
      end else if (do_step) begin
        addr_q <= addr_q + ADDR_ONE;
        cnt_q  <= cnt_q - CNT_ONE;
        sum_q  <= do_done ? fixed_sum : step_sum;
      end
    end
  end

  assign mem_addr     = addr_q;
  assign done         = done_q;
  assign interrupted  = intr_q;
  assign sum_out      = sum_q;
  assign next_addr    = addr_q;
  assign remain_count = cnt_q;

  assert_no_minus_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sum_out != {DATA_W{1'b1}}));
  assert_step_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && do_step) |=> (next_addr == $past(next_addr) + ADDR_ONE)
                        && (remain_count == $past(remain_count) - CNT_ONE));
  assert_stop_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && do_intr) |=> ($stable(sum_out) && $stable(remain_count)
                           && $stable(next_addr) && interrupted && !busy));
  assert_addr_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_addr));
  assert_pulses_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && interrupted));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sum_out) && $stable(remain_count)));
endmodule

// File: tb/cks_engine_bench.sv
module cks_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam logic [15:0] V_ADDR [NV] = '{16'd0, 16'd3, 16'd10, 16'd20, 16'd0, 16'd5};
  localparam logic [15:0] V_CNT  [NV] = '{16'd8, 16'd16, 16'd1, 16'd30, 16'd64, 16'd2};
  localparam logic [15:0] V_INIT [NV] = '{16'h0000, 16'h0000, 16'hABCD, 16'h1234, 16'h0000, 16'hFFFF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] start_addr = '0, start_sum = '0, start_count = '0;
  logic irq_req = 1'b0, irq_mask = 1'b0;
  logic mem_req_valid, mem_req_ready, busy, done, interrupted;
  logic [15:0] mem_addr, next_addr, remain_count, sum_out;
  logic [15:0] mem_rdata = '0;
  logic [15:0] mem [64];
  logic slow = 1'b0;
  int ph = 0;
  int reads = 0;
  int checks = 0, fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cks_engine u_cks_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_count(start_count), .start_sum(start_sum), .irq_req(irq_req),
    .irq_mask(irq_mask), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .interrupted(interrupted), .sum_out(sum_out), .next_addr(next_addr),
    .remain_count(remain_count));

  assign mem_req_ready = slow ? (ph == 2) : 1'b1;

  always @(negedge clk) ph <= (ph == 2) ? 0 : ph + 1;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_req_valid && mem_req_ready) begin
      mem_rdata <= mem[mem_addr[5:0]];
      reads <= reads + 1;
    end
  end

  always @(posedge clk) if (cycles > 150000) begin
    fails = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic logic [15:0] ref_raw(input logic [15:0] a, input int n, input logic [15:0] s);
    logic [16:0] w;
    logic [15:0] r;
    r = s;
    for (int i = 0; i < n; i++) begin
      w = {1'b0, r} + {1'b0, mem[6'(a + 16'(i))]};
      r = w[15:0] + {15'd0, w[16]};
      r = {r[14:0], r[15]};
    end
    return r;
  endfunction

  function automatic logic [15:0] fixz(input logic [15:0] v);
    return (v == 16'hFFFF) ? 16'h0000 : v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [15:0] a, input logic [15:0] n, input logic [15:0] s);
    @(negedge clk);
    start_addr = a; start_count = n; start_sum = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(output int edges);
    edges = 1;
    while (!done && !interrupted && edges < 5000) begin
      @(negedge clk);
      edges++;
    end
  endtask

  initial begin
    int e;
    logic [15:0] held_s, held_a, held_n, exp_v;
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h3A5B + 16'h1F0F) ^ 16'(i << 9);
    #(CLK_PERIOD * 3);
    chk("R10 reset done", {31'd0, done}, 0);
    chk("R10 reset busy", {31'd0, busy}, 0);
    chk("R9 reset req", {31'd0, mem_req_valid}, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < NV; v++) begin
        slow = (m == 1);
        launch(V_ADDR[v], V_CNT[v], V_INIT[v]);
        wait_end(e);
        chk("R4 vector done", {31'd0, done}, 1);
        chk("R4 vector sum", {16'd0, sum_out}, {16'd0, fixz(ref_raw(V_ADDR[v], int'(V_CNT[v]), V_INIT[v]))});
        chk("R4 vector count", {16'd0, remain_count}, 0);
        if (m == 0) chk("R9 cycles", e, 2 * int'(V_CNT[v]) + 1);
        else if (e > 9 * int'(V_CNT[v]) + 1) chk("R9 cycle bound", e, 9 * int'(V_CNT[v]) + 1);
      end
    end
    slow = 1'b0;

    mem[40] = 16'h8000;
    launch(16'd40, 16'd1, 16'h8000); wait_end(e);
    chk("R1 end-around carry", {16'd0, sum_out}, 32'h0002);
    mem[41] = 16'h8001;
    launch(16'd41, 16'd1, 16'h0000); wait_end(e);
    chk("R2 rotate", {16'd0, sum_out}, 32'h0003);
    launch(16'd40, 16'd1, 16'h7FFF); wait_end(e);
    chk("R3 minus zero", {16'd0, sum_out}, 32'h0000);
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, done}, 0);
    repeat (4) @(negedge clk);
    chk("R10 result stable", {16'd0, sum_out}, 32'h0000);

    e = reads;
    launch(16'd7, 16'd0, 16'hFFFF);
    chk("R8 zero count done", {31'd0, done}, 1);
    chk("R8 zero count sum", {16'd0, sum_out}, 0);
    launch(16'd7, 16'd0, 16'h1234);
    chk("R8 zero count init", {16'd0, sum_out}, 32'h1234);
    @(negedge clk);
    chk("R8 no reads", reads, e);

    irq_req = 1'b1; irq_mask = 1'b1;
    launch(16'd2, 16'd12, 16'h0000); wait_end(e);
    chk("R7 masked done", {31'd0, done}, 1);
    chk("R7 masked sum", {16'd0, sum_out}, {16'd0, fixz(ref_raw(16'd2, 12, 16'h0000))});

    irq_mask = 1'b0;
    launch(16'd9, 16'd5, 16'h0042); wait_end(e);
    chk("R5 immediate stop", {31'd0, interrupted}, 1);
    chk("R5 nothing added", {16'd0, sum_out}, 32'h0042);
    chk("R5 count kept", {16'd0, remain_count}, 5);
    chk("R5 addr kept", {16'd0, next_addr}, 9);
    irq_req = 1'b0;

    launch(16'd4, 16'd20, 16'h0000);
    repeat (9) @(negedge clk);
    irq_req = 1'b1;
    wait_end(e);
    irq_req = 1'b0;
    held_s = sum_out; held_a = next_addr; held_n = remain_count;
    chk("R5 interrupted", {31'd0, interrupted}, 1);
    chk("R5 no done", {31'd0, done}, 0);
    chk("R5 addr matches count", {16'd0, held_a}, {16'd0, 16'd4 + (16'd20 - held_n)});
    chk("R5 partial sum", {16'd0, held_s}, {16'd0, ref_raw(16'd4, int'(16'd20 - held_n), 16'h0000)});
    launch(held_a, held_n, held_s); wait_end(e);
    chk("R6 resumed sum", {16'd0, sum_out}, {16'd0, fixz(ref_raw(16'd4, 20, 16'h0000))});

    launch(16'd1, 16'd10, 16'h0000);
    repeat (3) @(negedge clk);
    start_addr = 16'd30; start_count = 16'd2; start_sum = 16'h5555; start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_end(e);
    exp_v = fixz(ref_raw(16'd1, 10, 16'h0000));
    chk("R10 start ignored", {16'd0, sum_out}, {16'd0, exp_v});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule